// File: doc/BRIEF.md
# Cascadable FIFO Buffer with Replay

This block is a first-in first-out store of 512 words of 9 bits. A producer presents a word and pulls an active-low write strobe; a consumer pulls an active-low read strobe and receives the oldest stored word. The empty and full flags keep the buffer from underflowing or overflowing. Both strobes, like all state changes, are sampled on the falling edge of one system clock. The data output is modelled as a register plus an output-enable signal, which is high only while the read strobe is held low.

In standalone or width-cascade use, the multi-purpose flag output reports that more than half of the buffer is occupied. A replay input rewinds the read side to location zero, so that the data written since reset can be read again. In depth-cascade use, several instances form one deeper buffer. Each instance owns a write turn and a read turn. When an instance passes the last location on either side, it gives up that turn with a one-cycle pulse on the multi-purpose output, which feeds the next instance's cascade input. The instance whose lead-select input is tied low starts with both turns.

A master reset input clears the block asynchronously. The release of this reset is synchronised, so the block accepts strobes from the third falling edge after the reset input rises.

Top module: `cascade_fifo`

## Requirements
- R1: Words are read back in the order they were written; an accepted read loads the oldest word onto `dout` at the falling edge that samples it, and `dout` otherwise holds its value.
- R2: After master reset, `empty` is 1, `full` is 0, `hf_xo` is 0 and `dout` is 0.
- R3: With 512 words stored, `full` is 1 and a write is ignored; the stored words are neither changed nor added to.
- R4: With no words stored, `empty` is 1 and a read is ignored; `dout` keeps its previous value.
- R5: `dout_oe` is 1 exactly while `rd_n` is 0, in every mode.
- R6: With `depth_mode` = 0, `hf_xo` is 1 when 257 or more words are stored and 0 at 256 or fewer.
- R7: With `depth_mode` = 0, a cycle with `rt_n` = 0 sets the read location to 0 and the word count to the write location, so the following reads replay from the first word written after reset.
- R8: Writes and reads sampled together with an active replay are ignored, and `rt_n` has no effect when `depth_mode` = 1.
- R9: With `depth_mode` = 1, an instance reset with `first_n` = 0 holds both the write and the read turn; one reset with `first_n` = 1 holds neither and ignores writes and reads.
- R10: With `depth_mode` = 1, `hf_xo` pulses high for one cycle after an accepted write to location 511 and after an accepted read from location 511; the instance then ignores writes (or reads, respectively) until it is given that turn back.
- R11: With `depth_mode` = 1, successive cycles with `xin` = 1 hand back the write turn and the read turn alternately, starting with the write turn after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; state changes on its falling edge |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| rt_n | input | 1 | Replay request, active low |
| din | input | 9 | Write data |
| depth_mode | input | 1 | 1 selects depth-cascade behaviour |
| first_n | input | 1 | Low on the instance that is loaded first |
| xin | input | 1 | Cascade input, one-cycle turn pulse from the previous instance |
| dout | output | 9 | Read data |
| dout_oe | output | 1 | Output enable for `dout` |
| empty | output | 1 | No words stored |
| full | output | 1 | 512 words stored |
| hf_xo | output | 1 | Over-half flag, or cascade turn pulse in depth mode |

## Verification
Every registered result (the flags, `dout`, and the turn pulse on `hf_xo`) changes at the falling edge that samples the strobe, half a period after the bench drives it on a rising edge. The bench therefore compares these results on the next rising edge, one step after the stimulus. `dout_oe` is combinational from `rd_n` and is compared one time unit after the strobe changes. After each master reset, the bench waits three rising edges so that the synchronised reset release has completed before the first strobe is sampled.

// File: rtl/cfx_pkg.sv
package cfx_pkg;
  parameter int CFX_WIDTH = 9;
  parameter int CFX_DEPTH = 512;
  // number of falling edges over which reset release is synchronised
  parameter int CFX_RST_STAGES = 2;
endpackage

// File: rtl/cfx_store.sv
module cfx_store #(
  parameter int WIDTH = cfx_pkg::CFX_WIDTH,
  parameter int DEPTH = cfx_pkg::CFX_DEPTH,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(negedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfx_ptr_ctl.sv
module cfx_ptr_ctl #(
  parameter int DEPTH = cfx_pkg::CFX_DEPTH,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          rt_req,
  input  logic          wr_turn,
  input  logic          rd_turn,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic          empty,
  output logic          full,
  output logic          half
);
  logic [AW-1:0] wptr_d, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          upd;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign half   = (cnt_q > CW'(DEPTH / 2));
  assign wr_acc = wr_req && !full  && wr_turn && !rt_req;
  assign rd_acc = rd_req && !empty && rd_turn && !rt_req;
  assign upd    = rt_req || wr_acc || rd_acc;

  always_comb begin
    wptr_d = wptr;
    rptr_d = rptr;
    cnt_d  = cnt_q;
    if (rt_req) begin
      rptr_d = '0;
      cnt_d  = {1'b0, wptr};
    end else begin
      if (wr_acc) wptr_d = wptr + 1'b1;
      if (rd_acc) rptr_d = rptr + 1'b1;
      cnt_d = cnt_q + CW'(wr_acc) - CW'(rd_acc);
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      cnt_q <= '0;
    end else if (upd) begin
      wptr  <= wptr_d;
      rptr  <= rptr_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/cfx_token.sv
module cfx_token (
  input  logic clk,
  input  logic rst_n,
  input  logic depth_mode,
  input  logic first_n,
  input  logic xin,
  input  logic wr_wrap,
  input  logic rd_wrap,
  output logic wr_tok,
  output logic rd_tok,
  output logic xo
);
  // each turn toggles between held and given away, so one flip bit per side
  logic wr_flip_q, rd_flip_q, exp_wr_q;
  logic wr_flip_d, rd_flip_d, exp_wr_d, xo_d;
  logic grant;

  assign grant  = depth_mode && xin;
  assign wr_tok = !first_n ^ wr_flip_q;
  assign rd_tok = !first_n ^ rd_flip_q;

  always_comb begin
    wr_flip_d = wr_flip_q ^ ((depth_mode && wr_wrap) || (grant && exp_wr_q));
    rd_flip_d = rd_flip_q ^ ((depth_mode && rd_wrap) || (grant && !exp_wr_q));
    exp_wr_d  = exp_wr_q ^ grant;
    xo_d      = depth_mode && (wr_wrap || rd_wrap);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_flip_q <= 1'b0;
      rd_flip_q <= 1'b0;
      exp_wr_q  <= 1'b1;
      xo        <= 1'b0;
    end else begin
      wr_flip_q <= wr_flip_d;
      rd_flip_q <= rd_flip_d;
      exp_wr_q  <= exp_wr_d;
      xo        <= xo_d;
    end
  end
endmodule

// File: rtl/cascade_fifo.sv
module cascade_fifo #(
  parameter int WIDTH = cfx_pkg::CFX_WIDTH,
  parameter int DEPTH = cfx_pkg::CFX_DEPTH,
  localparam int AW = $clog2(DEPTH),
  localparam int RS = cfx_pkg::CFX_RST_STAGES
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             rt_n,
  input  logic [WIDTH-1:0] din,
  input  logic             depth_mode,
  input  logic             first_n,
  input  logic             xin,
  output logic [WIDTH-1:0] dout,
  output logic             dout_oe,
  output logic             empty,
  output logic             full,
  output logic             hf_xo
);
  logic [RS-1:0] rst_sync;
  logic          rst_n;
  logic          wr_acc, rd_acc, half, xo, wr_tok, rd_tok;
  logic [AW-1:0] wptr, rptr;

  always_ff @(negedge clk or negedge mrst_n) begin
    if (!mrst_n) rst_sync <= '0;
    else         rst_sync <= {rst_sync[RS-2:0], 1'b1};
  end
  assign rst_n = rst_sync[RS-1];

  cfx_ptr_ctl #(.DEPTH(DEPTH)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .wr_req(!wr_n), .rd_req(!rd_n), .rt_req(!rt_n && !depth_mode),
    .wr_turn(!depth_mode || wr_tok), .rd_turn(!depth_mode || rd_tok),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .wptr(wptr), .rptr(rptr),
    .empty(empty), .full(full), .half(half)
  );

  cfx_token u_tok (
    .clk(clk), .rst_n(rst_n), .depth_mode(depth_mode), .first_n(first_n),
    .xin(xin),
    .wr_wrap(wr_acc && (wptr == AW'(DEPTH - 1))),
    .rd_wrap(rd_acc && (rptr == AW'(DEPTH - 1))),
    .wr_tok(wr_tok), .rd_tok(rd_tok), .xo(xo)
  );

  cfx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_acc), .waddr(wptr), .wdata(din),
    .rd_en(rd_acc), .raddr(rptr), .rdata(dout)
  );

  assign dout_oe = !rd_n;
  assign hf_xo   = depth_mode ? xo : half;
endmodule

// File: rtl/cascade_fifo_chk.sv
module cascade_fifo_chk #(
  parameter int WIDTH = 9,
  parameter int AW = 9
) (
  input logic             clk,
  input logic             mrst_n,
  input logic             wr_n,
  input logic             rd_n,
  input logic             rt_n,
  input logic             depth_mode,
  input logic             empty,
  input logic             full,
  input logic             wr_tok,
  input logic             rd_tok,
  input logic [AW-1:0]    wptr,
  input logic [AW-1:0]    rptr,
  input logic [WIDTH-1:0] dout
);
  a_r2_flags_exclusive: assert property (@(negedge clk) disable iff (!mrst_n)
    !(empty && full));

  a_r3_no_overflow: assert property (@(negedge clk) disable iff (!mrst_n)
    (full && rd_n && rt_n) |=> full);

  a_r4_no_underflow: assert property (@(negedge clk) disable iff (!mrst_n)
    (empty && wr_n && rt_n) |=> (empty && $stable(rptr) && $stable(dout)));

  a_r7_rt_rewind: assert property (@(negedge clk) disable iff (!mrst_n)
    (!depth_mode && !rt_n) |=> (rptr == '0));

  a_r8_rt_hold: assert property (@(negedge clk) disable iff (!mrst_n)
    (!depth_mode && !rt_n) |=> ($stable(wptr) && $stable(dout)));

  a_r9_wr_gate: assert property (@(negedge clk) disable iff (!mrst_n)
    (depth_mode && !wr_tok) |=> $stable(wptr));

  a_r9_rd_gate: assert property (@(negedge clk) disable iff (!mrst_n)
    (depth_mode && !rd_tok) |=> ($stable(rptr) && $stable(dout)));
endmodule

bind cascade_fifo cascade_fifo_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .mrst_n(mrst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
  .depth_mode(depth_mode), .empty(empty), .full(full),
  .wr_tok(wr_tok), .rd_tok(rd_tok), .wptr(wptr), .rptr(rptr), .dout(dout)
);

// File: tb/test_cascade_fifo.sv
module test_cascade_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int W = 9;
  localparam int D = 512;

  logic         clk = 1'b0;
  logic         mrst_n, wr_n, rd_n, rt_n, depth_mode, first_n, xin;
  logic [W-1:0] din, dout;
  logic         dout_oe, empty, full, hf_xo;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] mm [D];
  int           mwp, mrp, mcnt;
  bit           mwt, mrt, mexp, mxo, mdepth;
  logic [W-1:0] mdout;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cascade_fifo i_cascade_fifo (
    .clk(clk), .mrst_n(mrst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .depth_mode(depth_mode), .first_n(first_n), .xin(xin),
    .dout(dout), .dout_oe(dout_oe), .empty(empty), .full(full), .hf_xo(hf_xo)
  );

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_hf();
    return mdepth ? mxo : (mcnt > D / 2);
  endfunction

  task automatic model(input bit w, input bit r, input bit rt, input bit x,
                       input logic [W-1:0] d);
    bit wok, rok, wwrap, rwrap;
    wwrap = 0; rwrap = 0;
    if (!rt && !mdepth) begin
      mrp = 0; mcnt = mwp; mxo = 0;
    end else begin
      wok = !w && mcnt < D && (!mdepth || mwt);
      rok = !r && mcnt > 0 && (!mdepth || mrt);
      if (rok) begin mdout = mm[mrp]; rwrap = (mrp == D - 1); mrp = (mrp + 1) % D; end
      if (wok) begin mm[mwp] = d; wwrap = (mwp == D - 1); mwp = (mwp + 1) % D; end
      mcnt = mcnt + int'(wok) - int'(rok);
      mxo = mdepth && (wwrap || rwrap);
      if (mdepth && wwrap) mwt = 0;
      if (mdepth && rwrap) mrt = 0;
    end
    if (mdepth && x) begin
      if (mexp) mwt = 1; else mrt = 1;
      mexp = !mexp;
    end
  endtask

  task automatic compare(input string tag);
    check({tag, " empty"}, int'(empty), int'(mcnt == 0));
    check({tag, " full"},  int'(full),  int'(mcnt == D));
    check({tag, " hf_xo"}, int'(hf_xo), int'(exp_hf()));
    check({tag, " dout"},  int'(dout),  int'(mdout));
  endtask

  // drive at a rising edge, design samples at the falling edge, compare at the next rising edge
  task automatic step(input bit w, input bit r, input bit rt, input bit x,
                      input logic [W-1:0] d, input string tag);
    wr_n = w; rd_n = r; rt_n = rt; xin = x; din = d;
    #1 check("R5 dout_oe", int'(dout_oe), int'(!r));
    model(w, r, rt, x, d);
    @(posedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input bit dm, input bit fn);
    mrst_n = 0; wr_n = 1; rd_n = 1; rt_n = 1; xin = 0; din = '0;
    depth_mode = dm; first_n = fn;
    repeat (2) @(posedge clk);
    mrst_n = 1;
    repeat (3) @(posedge clk);
    mwp = 0; mrp = 0; mcnt = 0; mwt = !fn; mrt = !fn; mexp = 1; mxo = 0;
    mdepth = dm; mdout = '0;
    compare("R2 reset");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    mrst_n = 0;
    @(posedge clk);

    // R4: reads on empty are ignored; R1 basic order
    do_reset(0, 1);
    step(1, 0, 1, 0, 9'h0AA, "R4 read empty");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 9'(i * 37 + 5), "R1 write");
    for (int i = 0; i < 7; i++) step(1, 0, 1, 0, '0, "R1 read order");

    // R6: half-full boundary at 256/257, R3 overflow
    do_reset(0, 1);
    for (int i = 0; i < 256; i++) step(0, 1, 1, 0, 9'($urandom), "R6 fill to 256");
    check("R6 hf at 256", int'(hf_xo), 0);
    step(0, 1, 1, 0, 9'h101, "R6 257th word");
    check("R6 hf at 257", int'(hf_xo), 1);
    step(1, 0, 1, 0, '0, "R6 back to 256");
    for (int i = 0; i < 260; i++) step(0, 1, 1, 0, 9'($urandom), "R3 fill");
    check("R3 full", int'(full), 1);
    step(0, 0, 1, 0, 9'h1FF, "R3 write and read when full");
    step(0, 1, 1, 0, 9'h1EE, "R3 refill");
    step(0, 1, 1, 0, 9'h1DD, "R3 write ignored");
    for (int i = 0; i < 514; i++) step(1, 0, 1, 0, '0, "R3 drain");

    // R7 replay and R8 strobes during replay ignored
    do_reset(0, 1);
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 9'(i + 9'h40), "R7 write");
    for (int i = 0; i < 5; i++) step(1, 0, 1, 0, '0, "R7 read");
    step(0, 0, 0, 0, 9'h155, "R8 strobes during replay");
    check("R7 not empty after replay", int'(empty), 0);
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, '0, "R7 replayed data");

    // R8: replay ignored in depth mode
    do_reset(1, 0);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 0, 9'(i + 9'h70), "R8 write");
    for (int i = 0; i < 2; i++) step(1, 0, 1, 0, '0, "R8 read");
    step(1, 1, 0, 0, '0, "R8 replay in depth mode");
    step(1, 0, 1, 0, '0, "R8 read continues");
    check("R8 word after ignored replay", int'(dout), 9'h72);

    // R9, R10, R11: lead instance turn passing
    do_reset(1, 0);
    for (int i = 0; i < 511; i++) step(0, 1, 1, 0, 9'($urandom), "R9 lead writes");
    step(0, 1, 1, 0, 9'h0C3, "R10 write wrap");
    check("R10 pulse on write wrap", int'(hf_xo), 1);
    step(1, 1, 1, 0, '0, "R10 pulse ends");
    step(1, 0, 1, 0, '0, "R10 read");
    step(0, 1, 1, 0, 9'h011, "R10 write without turn");
    check("R10 write ignored", int'(full), 0);
    for (int i = 0; i < 511; i++) step(1, 0, 1, 0, '0, "R10 drain");
    check("R10 pulse on read wrap", int'(hf_xo), 1);
    step(0, 1, 1, 0, 9'h022, "R10 write still without turn");
    step(1, 1, 1, 1, '0, "R11 write turn back");
    step(0, 1, 1, 0, 9'h033, "R11 write with turn");
    step(1, 0, 1, 0, '0, "R11 read without turn");
    check("R11 read ignored", int'(empty), 0);
    step(1, 1, 1, 1, '0, "R11 read turn back");
    step(1, 0, 1, 0, '0, "R11 read with turn");
    check("R11 word", int'(dout), 9'h033);

    // R9: non-lead instance starts without turns
    do_reset(1, 1);
    step(0, 1, 1, 0, 9'h0F0, "R9 non-lead write ignored");
    step(1, 1, 1, 1, '0, "R11 grant write");
    step(0, 1, 1, 0, 9'h0F1, "R9 write after grant");
    step(1, 0, 1, 0, '0, "R9 read ignored without turn");
    step(1, 1, 1, 1, '0, "R11 grant read");
    step(1, 0, 1, 0, '0, "R9 read after grant");

    // constrained random, standalone
    do_reset(0, 1);
    for (int i = 0; i < 6000; i++) begin
      int bias;
      bit w, r, rt;
      bias = ((i / 700) % 2 == 0) ? 80 : 25;
      w  = !(($urandom % 100) < bias);
      r  = !(($urandom % 100) < (100 - bias));
      rt = !(($urandom % 250) == 0);
      step(w, r, rt, 0, 9'($urandom), "R1 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule